// File: doc/BRIEF.md
# Eight-Channel Prescaled PWM Generator

This block produces eight pulse-width-modulated outputs that share one time base. A programmable prescaler divides the core clock. Its terminal count advances a shared period counter, which runs from zero up to a programmable limit and then wraps. Each channel compares the period counter against its own duty value to produce its output. A per-channel polarity bit can invert that output.

Software reaches the block through a simple synchronous register port. A write lands on the rising clock edge, and read data reflects the addressed register combinationally. When the control register's run bit is clear, the time base is stopped and held at zero. In that state every output rests at its polarity level, and all registers stay readable and writable. Setting the run bit starts a fresh, complete period.

A second control bit selects the prescaler width. When it is clear, only the low byte of the prescaler register counts. When it is set, all sixteen bits count.

Top module: `pwm8_gen`

## Requirements
- R1: With the run bit set, the divisor N is the prescaler value plus one, and the period limit is C. The shared period counter advances once every N clocks and wraps after C, so every channel repeats with a period of N×(C+1) clocks.
- R2: Take the non-inverted channel i, with duty value D below C. In each period it is high for the first D+1 prescaled ticks (counter at or below D) and low for the rest.
- R3: A channel whose duty value is greater than C is low for the whole period, before any inversion.
- R4: A channel whose duty value equals C is high continuously, before any inversion.
- R5: Polarity bit i at 1 makes output i the complement of its non-inverted waveform.
- R6: With the run bit clear, each output equals its polarity bit, and the counters hold at zero. Writes and reads of all registers still work, and stored values are retained.
- R7: Control bit 1 (wide) at 0 makes the divisor prescaler[7:0]+1, so a write to the upper byte has no effect on timing. At 1 the divisor is prescaler[15:0]+1.
- R8: After reset all registers read zero and all outputs are low.
- R9: The cycle after the run bit goes from 0 to 1, the time base stands at the start of a period. The first period is full length.
- R10: The register addresses are 0 prescaler, 1 period limit, 2 polarity (bits 7:0), 3 control (bit 0 run, bit 1 wide), and 8+i duty of channel i. Unused bits and addresses 4 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| pwm_o | output | 8 | PWM outputs, bit i is channel i |

## Verification
A prescaler counting to the wrong limit stretches or shrinks every tick. That shows within the first period as an edge that arrives early or late on every active channel. A period counter that wraps at the wrong value shifts the duty edges by the second period. A broken compare or special case is visible on the affected channel within one period. A stale counter left over from a power-off shows in the first cycles after the run bit rises, because the bench compares every cycle from that point. Register faults show immediately on readback.

// File: rtl/pwm8_pkg.sv
// Shared constants for the eight-channel PWM generator: data widths,
// channel count and the register address map.
package pwm8_pkg;
    localparam int unsigned DW  = 16;
    localparam int unsigned NCH = 8;
    localparam int unsigned AW  = 4;

    localparam logic [AW-1:0] A_PRE   = 4'd0;
    localparam logic [AW-1:0] A_PER   = 4'd1;
    localparam logic [AW-1:0] A_POL   = 4'd2;
    localparam logic [AW-1:0] A_CTL   = 4'd3;
    localparam int unsigned   A_DUTY0 = 8;

    localparam int unsigned CTL_RUN  = 0;
    localparam int unsigned CTL_WIDE = 1;
endpackage

// File: rtl/pwm8_regs.sv
// Register file of the PWM generator.
// Holds prescaler, period limit, per-channel duty, polarity and control.
// Assumes writes are single-cycle strobes; read data is combinational.
module pwm8_regs
    import pwm8_pkg::*;
#(
    parameter int unsigned W = DW,
    parameter int unsigned N = NCH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [W-1:0]        wdata,
    output logic [W-1:0]        rdata,
    output logic [W-1:0]        prsc,
    output logic [W-1:0]        ctr,
    output logic [N-1:0][W-1:0] duty,
    output logic [N-1:0]        pol,
    output logic                run,
    output logic                wide
);
    // Register update on write strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prsc <= '0;
            ctr  <= '0;
            duty <= '0;
            pol  <= '0;
            run  <= 1'b0;
            wide <= 1'b0;
        end else if (we) begin
            case (addr)
                A_PRE: prsc <= wdata;
                A_PER: ctr  <= wdata;
                A_POL: pol  <= wdata[N-1:0];
                A_CTL: begin
                    run  <= wdata[CTL_RUN];
                    wide <= wdata[CTL_WIDE];
                end
                default: ;
            endcase
            for (int i = 0; i < int'(N); i++) begin
                if (addr == AW'(A_DUTY0 + i)) duty[i] <= wdata;
            end
        end
    end

    // Read multiplexer over the address map.
    always_comb begin
        rdata = '0;
        case (addr)
            A_PRE: rdata = prsc;
            A_PER: rdata = ctr;
            A_POL: rdata[N-1:0] = pol;
            A_CTL: begin
                rdata[CTL_RUN]  = run;
                rdata[CTL_WIDE] = wide;
            end
            default: ;
        endcase
        for (int i = 0; i < int'(N); i++) begin
            if (addr == AW'(A_DUTY0 + i)) rdata = duty[i];
        end
    end

    assert_wr_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_PER) |=> (ctr == $past(wdata)));
    assert_wr_prsc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_PRE) |=> (prsc == $past(wdata)));
endmodule

// File: rtl/pwm8_timebase.sv
// Shared time base: prescaler followed by the period counter.
// Assumes prescaler, width and period limit change only while stopped.
// While run is low both counters are held at zero.
module pwm8_timebase
    import pwm8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         wide,
    input  logic [W-1:0] prsc,
    input  logic [W-1:0] ctr,
    output logic [W-1:0] per_cnt
);
    localparam int unsigned HW = W / 2;

    logic [W-1:0] pre_cnt;
    logic [W-1:0] limit;
    logic         tick;

    // Select the active prescaler width.
    always_comb begin
        limit = wide ? prsc : {{(W-HW){1'b0}}, prsc[HW-1:0]};
        tick  = (pre_cnt >= limit);
    end

    // Advance prescaler every clock and period counter on each terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            per_cnt <= '0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
            if (tick) per_cnt <= (per_cnt >= ctr) ? '0 : per_cnt + 1'b1;
        end
    end

    assert_hold_between_ticks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(per_cnt));
    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && per_cnt >= ctr) |=> (per_cnt == '0));
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (pre_cnt == '0 && per_cnt == '0));
endmodule

// File: rtl/pwm8_channel.sv
// One PWM channel: duty compare with forced-low and forced-high cases,
// polarity inversion, and idle level while the time base is stopped.
module pwm8_channel
    import pwm8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         inv,
    input  logic [W-1:0] duty,
    input  logic [W-1:0] ctr,
    input  logic [W-1:0] per_cnt,
    output logic         pwm
);
    logic raw;

    // Compare with special duty cases taking priority.
    always_comb begin
        if (duty > ctr)       raw = 1'b0;
        else if (duty == ctr) raw = 1'b1;
        else                  raw = (per_cnt <= duty);
        pwm = run ? (raw ^ inv) : inv;
    end

    assert_forced_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty > ctr) |-> (pwm == inv));
    assert_forced_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && duty == ctr) |-> (pwm == !inv));
endmodule

// File: rtl/pwm8_gen.sv
// Top of the eight-channel prescaled PWM generator.
// Ties the register file, the shared time base and one channel per output.
module pwm8_gen
    import pwm8_pkg::*;
#(
    parameter int unsigned W = DW,
    parameter int unsigned N = NCH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    output logic [N-1:0]  pwm_o
);
    logic [W-1:0]        prsc;
    logic [W-1:0]        ctr;
    logic [N-1:0][W-1:0] duty;
    logic [N-1:0]        pol;
    logic                run;
    logic                wide;
    logic [W-1:0]        per_cnt;

    pwm8_regs #(.W(W), .N(N)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .prsc(prsc), .ctr(ctr),
        .duty(duty), .pol(pol), .run(run), .wide(wide)
    );

    pwm8_timebase #(.W(W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run), .wide(wide),
        .prsc(prsc), .ctr(ctr), .per_cnt(per_cnt)
    );

    for (genvar g = 0; g < int'(N); g++) begin : g_ch
        pwm8_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(run), .inv(pol[g]),
            .duty(duty[g]), .ctr(ctr), .per_cnt(per_cnt), .pwm(pwm_o[g])
        );
    end

    assert_idle_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm_o == pol));
endmodule

// File: tb/pwm8_gen_tb.sv
// Self-checking bench: a vector table of time-base settings walked by one
// loop, followed by directed tests for reset, power-off and readback.
module pwm8_gen_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] prsc;
        logic        wide;
        logic [15:0] ctr;
        logic [15:0] dbase;
        logic [7:0]  inv;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 1'b0, 16'd3, 16'h0000, 8'h00},  // R2 R3 R4 fastest tick
        '{16'h0002, 1'b0, 16'd4, 16'h0000, 8'hA5},  // R1 R5 divide by 3
        '{16'hFF01, 1'b0, 16'd5, 16'h0001, 8'h00},  // R7 upper byte ignored
        '{16'h0003, 1'b1, 16'd2, 16'hFFFE, 8'hF0},  // R3 R5 duty wraps past limit
        '{16'h0000, 1'b1, 16'd0, 16'h0000, 8'h00},  // R4 zero limit
        '{16'h0101, 1'b1, 16'd1, 16'h0000, 8'h00}   // R7 wide divide by 258
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  pwm_o;

    int errors = 0;
    int checks = 0;

    pwm8_gen u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] expect_out(input vec_t v, input int k);
        int div, phase;
        logic [7:0] o;
        div = v.wide ? int'(v.prsc) + 1 : int'(v.prsc[7:0]) + 1;
        phase = (k / div) % (int'(v.ctr) + 1);
        for (int c = 0; c < 8; c++) begin
            logic [15:0] d;
            d = v.dbase + 16'(c);
            if (d > v.ctr)       o[c] = 1'b0;
            else if (d == v.ctr) o[c] = 1'b1;
            else                 o[c] = (phase <= int'(d));
        end
        return o ^ v.inv;
    endfunction

    // Program a vector while stopped, then start it.
    task automatic load(input vec_t v);
        wr(4'd3, {14'd0, v.wide, 1'b0});
        wr(4'd0, v.prsc);
        wr(4'd1, v.ctr);
        for (int c = 0; c < 8; c++) wr(4'(8 + c), v.dbase + 16'(c));
        wr(4'd2, {8'd0, v.inv});
        #1;
        check("R6 idle level", {8'd0, pwm_o}, {8'd0, v.inv});
    endtask

    // Enable and compare every cycle for two periods (R1 R2 R9).
    task automatic run_cmp(input vec_t v, input string tag);
        int n;
        n = 2 * (v.wide ? int'(v.prsc) + 1 : int'(v.prsc[7:0]) + 1) * (int'(v.ctr) + 1);
        wr(4'd3, {14'd0, v.wide, 1'b1});
        for (int k = 0; k < n; k++) begin
            #1;
            check(tag, {8'd0, pwm_o}, {8'd0, expect_out(v, k)});
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8 outputs", {8'd0, pwm_o}, 16'd0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check("R8 register zero", d, 16'd0);
        end

        for (int i = 0; i < NVEC; i++) begin
            load(VECS[i]);
            run_cmp(VECS[i], "R1/R2/R3/R4/R5/R7 waveform");
        end

        // R6 power-off: outputs idle, registers retained and writable
        wr(4'd2, 16'h003C);
        wr(4'd3, 16'h0000);
        for (int k = 0; k < 5; k++) begin
            #1;
            check("R6 off level", {8'd0, pwm_o}, 16'h003C);
            @(negedge clk);
        end
        rd(4'd0, d); check("R6 prescaler kept", d, 16'h0101);
        rd(4'd1, d); check("R6 limit kept", d, 16'd1);
        wr(4'd9, 16'h1234);
        rd(4'd9, d); check("R6 write while off", d, 16'h1234);

        // R9 restart after off gives a full first period
        load(VECS[1]);
        run_cmp(VECS[1], "R9 restart");
        wr(4'd3, 16'h0000);
        run_cmp(VECS[1], "R9 second restart");

        // R10 map: unused bits and holes read zero
        wr(4'd3, 16'hFFFC);
        wr(4'd2, 16'hFFFF);
        rd(4'd2, d); check("R10 polarity width", d, 16'h00FF);
        rd(4'd3, d); check("R10 control bits", d, 16'h0000);
        wr(4'd5, 16'hBEEF);
        rd(4'd5, d); check("R10 hole reads zero", d, 16'h0000);
        wr(4'd15, 16'hA5A5);
        rd(4'd15, d); check("R10 duty 7", d, 16'hA5A5);

        // R7 upper byte: narrow mode with 0x0300 divides by 1
        wr(4'd2, 16'h0000);
        load('{16'h0300, 1'b0, 16'd2, 16'h0000, 8'h00});
        run_cmp('{16'h0300, 1'b0, 16'd2, 16'h0000, 8'h00}, "R7 narrow ignores high byte");

        // R8 reset while running
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 outputs after reset", {8'd0, pwm_o}, 16'd0);
        rd(4'd0, d); check("R8 prescaler cleared", d, 16'd0);
        rd(4'd3, d); check("R8 control cleared", d, 16'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule